// File: doc/BRIEF.md
# Nibble Microcontroller Core

A small processor core for a 4-bit datapath. Every program word is one nibble. The core keeps four working registers (A, B, Y, Z), a shadow copy of each, and a single status flag. That flag both reports results and gates control flow. Instructions are one, two or three nibbles long and are fetched from a shared nibble store.

The store holds program nibbles at addresses 0x00–0x4F. A sixteen-entry data window sits at 0x50 plus the Y register. The store is filled through a write port while the core is held in reset.

The core reads a hex keypad (a code plus a valid bit). It drives a 4-bit display latch with a one-cycle update strobe and a bank of seven indicator lights. It sends one-cycle tone requests that carry a tone index. It raises a wait request with a length in tenths of a second and stalls until an external timer reports completion. Sound generation and real-time delay measurement are left to the surrounding logic.

Top module: `nib_core`

## Requirements
- R1: After reset the PC, all registers, the display and the lights are zero, the flag is 1, and fetch starts at address 0. A one-nibble instruction takes 1 cycle, an operand instruction takes 2, and a jump takes 3. Opcodes are: 0 KEY, 1 SHOW, 2 XAB, 3 XAY, 4 STM, 5 LDM, 6 ADM, 7 SBM, 8 LIA, 9 AIA, A LIY, B AIY, C CIA, D CIY, E JMP, F EXT.
- R2: KEY (0) with key_valid high copies key_code into A and clears the flag. With key_valid low, KEY sets the flag to 1 and leaves A unchanged.
- R3: All of the following set the flag to 1:
  - XAB (2) swaps A with B and Y with Z.
  - XAY (3) swaps A with Y.
  - STM (4) writes A to address 0x50+Y.
  - LDM (5) loads A from address 0x50+Y.
  - SHOW (1) copies A to disp and pulses disp_load one cycle later.
- R4: ADM (6) sets A to the low 4 bits of A plus mem[0x50+Y], and the flag to the carry out. SBM (7) sets A to the low 4 bits of A minus mem[0x50+Y], and the flag to 1 when the difference is negative.
- R5: The operand instructions each consume the next nibble:
  - LIA (8) loads it into A; LIY (A) loads it into Y. Both set the flag to 1.
  - AIA (9) adds it to A; AIY (B) adds it to Y. Both set the flag to the carry out.
- R6: CIA (C) and CIY (D) compare A or Y with the next nibble and consume it. The flag becomes 1 when the values differ and 0 when they are equal.
- R7: JMP (E) reads a high nibble and then a low nibble. With the flag at 1 it loads the PC with {high, low}. Otherwise it continues after the two nibbles and sets the flag to 1.
- R8: EXT (F) reads one call nibble. The call runs only when the flag is 1; when skipped, no state changes, including the flag. An executed call sets the flag to 1, except SHR. Unassigned call codes do nothing.
- R9: Call 4 complements A. Call 6 shifts A right one place and sets the flag to 1 when the original A was even, 0 when it was odd.
- R10: Call 5 exchanges A, B, Y and Z with their shadow registers.
- R11: Call 1 turns on light Y and call 2 turns it off. A Y value of 7 or more changes no light.
- R12: Call B pulses tone_req for exactly one cycle with tone_idx equal to A. It does not stall.
- R13: Call C raises wait_req with wait_len equal to A+1. The core stays stalled with no instruction executing until timer_done is seen high, and then resumes at the next instruction.
- R14: Call 0 clears the display and pulses disp_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Store write enable for program preload |
| load_addr | input | 8 | Preload nibble address |
| load_data | input | 4 | Preload nibble value |
| key_valid | input | 1 | A key is pressed |
| key_code | input | 4 | Hex code of the pressed key |
| timer_done | input | 1 | External pause has elapsed |
| disp | output | 4 | Display latch value |
| disp_load | output | 1 | One-cycle strobe: disp was just written |
| led | output | 7 | Indicator lights |
| tone_req | output | 1 | One-cycle tone request |
| tone_idx | output | 4 | Tone index carried with tone_req |
| wait_req | output | 1 | Pause requested, core stalled |
| wait_len | output | 5 | Pause length in tenths of a second |

## Verification
SHOW and call 0 update disp and disp_load on the clock edge that ends the cycle in which the opcode or call nibble is fetched. A tone request appears on the edge after the call nibble, and wait_req rises on that same edge. Because each program runs through many instructions of different lengths, the checks do not count cycles. They key on the strobes instead: each disp_load or tone_req, sampled on the falling edge, is compared with the next expected item in its queue. Wait length, stall duration and final light state are sampled only once the core has settled into its closing self-loop.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int NIB_W = 4;
    localparam int PC_W  = 2 * NIB_W;
    localparam int LED_N = 7;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [NIB_W-1:0] {
        OP_KEY, OP_SHOW, OP_XAB, OP_XAY, OP_STM, OP_LDM, OP_ADM, OP_SBM,
        OP_LIA, OP_AIA, OP_LIY, OP_AIY, OP_CIA, OP_CIY, OP_JMP, OP_EXT
    } op_e;

    localparam nib_t X_CLR  = 4'h0;
    localparam nib_t X_LON  = 4'h1;
    localparam nib_t X_LOFF = 4'h2;
    localparam nib_t X_CMPL = 4'h4;
    localparam nib_t X_SWAP = 4'h5;
    localparam nib_t X_SHR  = 4'h6;
    localparam nib_t X_TONE = 4'hB;
    localparam nib_t X_WAIT = 4'hC;

    typedef enum logic [1:0] { ST_OP, ST_ARG, ST_LO, ST_WAIT } st_e;

    typedef struct packed {
        st_e              st;
        logic [PC_W-1:0]  pc;
        op_e              op;
        nib_t             hi;
        nib_t             a, b, y, z;
        nib_t             sa, sb, sy, sz;
        logic             flag;
        nib_t             disp;
        logic             disp_load;
        logic [LED_N-1:0] led;
        logic             tone_req;
        nib_t             tone_idx;
        logic             wait_req;
        logic [NIB_W:0]   wait_len;
    } core_t;
endpackage

// File: rtl/nib_mem.sv
module nib_mem #(
    parameter int DEPTH  = 96,
    parameter int ADDR_W = 8,
    parameter int W      = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [W-1:0]      wd,
    input  logic [ADDR_W-1:0] ra_i,
    output logic [W-1:0]      rd_i,
    input  logic [ADDR_W-1:0] ra_d,
    output logic [W-1:0]      rd_d
);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(wa) < DEPTH)) cell_q[wa[IW-1:0]] <= wd;
    end

    always_comb begin
        rd_i = (int'(ra_i) < DEPTH) ? cell_q[ra_i[IW-1:0]] : '0;
        rd_d = (int'(ra_d) < DEPTH) ? cell_q[ra_d[IW-1:0]] : '0;
    end
endmodule

// File: rtl/nib_addsub.sv
module nib_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         co
);
    logic [W:0] full;
    always_comb begin
        full = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        res  = full[W-1:0];
        co   = full[W];
    end
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
#(
    parameter int MEM_DEPTH = 96,
    parameter int DATA_BASE = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_we,
    input  logic [PC_W-1:0]  load_addr,
    input  logic [NIB_W-1:0] load_data,
    input  logic             key_valid,
    input  logic [NIB_W-1:0] key_code,
    input  logic             timer_done,
    output logic [NIB_W-1:0] disp,
    output logic             disp_load,
    output logic [LED_N-1:0] led,
    output logic             tone_req,
    output logic [NIB_W-1:0] tone_idx,
    output logic             wait_req,
    output logic [NIB_W:0]   wait_len
);
    core_t q, d;

    nib_t            ins, dat, alu_a, alu_b, alu_r;
    logic            alu_sub, alu_c;
    logic            core_we;
    logic [PC_W-1:0] data_addr;

    assign data_addr = PC_W'(DATA_BASE) + {{(PC_W-NIB_W){1'b0}}, q.y};

    nib_mem #(.DEPTH(MEM_DEPTH), .ADDR_W(PC_W), .W(NIB_W)) mem_i (
        .clk  (clk),
        .we   (load_we | core_we),
        .wa   (load_we ? load_addr : data_addr),
        .wd   (load_we ? load_data : q.a),
        .ra_i (q.pc),
        .rd_i (ins),
        .ra_d (data_addr),
        .rd_d (dat)
    );

    always_comb begin
        if (q.st == ST_OP) begin
            alu_a   = q.a;
            alu_b   = dat;
            alu_sub = (op_e'(ins) == OP_SBM);
        end else begin
            alu_a   = (q.op == OP_AIY) ? q.y : q.a;
            alu_b   = ins;
            alu_sub = 1'b0;
        end
    end

    nib_addsub #(.W(NIB_W)) alu_i (
        .a (alu_a), .b (alu_b), .sub (alu_sub), .res (alu_r), .co (alu_c)
    );

    always_comb begin
        d           = q;
        d.disp_load = 1'b0;
        d.tone_req  = 1'b0;
        core_we     = 1'b0;
        case (q.st)
            ST_OP: begin
                d.pc = q.pc + 1'b1;
                case (op_e'(ins))
                    OP_KEY: begin
                        if (key_valid) begin
                            d.a    = key_code;
                            d.flag = 1'b0;
                        end else begin
                            d.flag = 1'b1;
                        end
                    end
                    OP_SHOW: begin
                        d.disp      = q.a;
                        d.disp_load = 1'b1;
                        d.flag      = 1'b1;
                    end
                    OP_XAB: begin
                        d.a = q.b; d.b = q.a; d.y = q.z; d.z = q.y;
                        d.flag = 1'b1;
                    end
                    OP_XAY: begin
                        d.a = q.y; d.y = q.a;
                        d.flag = 1'b1;
                    end
                    OP_STM: begin
                        core_we = 1'b1;
                        d.flag  = 1'b1;
                    end
                    OP_LDM: begin
                        d.a    = dat;
                        d.flag = 1'b1;
                    end
                    OP_ADM, OP_SBM: begin
                        d.a    = alu_r;
                        d.flag = alu_c;
                    end
                    default: begin
                        d.op = op_e'(ins);
                        d.st = ST_ARG;
                    end
                endcase
            end
            ST_ARG: begin
                d.pc = q.pc + 1'b1;
                d.st = ST_OP;
                case (q.op)
                    OP_LIA: begin d.a = ins; d.flag = 1'b1; end
                    OP_LIY: begin d.y = ins; d.flag = 1'b1; end
                    OP_AIA: begin d.a = alu_r; d.flag = alu_c; end
                    OP_AIY: begin d.y = alu_r; d.flag = alu_c; end
                    OP_CIA: d.flag = (q.a != ins);
                    OP_CIY: d.flag = (q.y != ins);
                    OP_JMP: begin d.hi = ins; d.st = ST_LO; end
                    OP_EXT: begin
                        if (q.flag) begin
                            case (ins)
                                X_CLR: begin d.disp = '0; d.disp_load = 1'b1; end
                                X_LON, X_LOFF: begin
                                    for (int i = 0; i < LED_N; i++) begin
                                        if (q.y == NIB_W'(i)) d.led[i] = (ins == X_LON);
                                    end
                                end
                                X_CMPL: d.a = ~q.a;
                                X_SWAP: begin
                                    d.a = q.sa; d.sa = q.a; d.b = q.sb; d.sb = q.b;
                                    d.y = q.sy; d.sy = q.y; d.z = q.sz; d.sz = q.z;
                                end
                                X_TONE: begin d.tone_req = 1'b1; d.tone_idx = q.a; end
                                X_WAIT: begin
                                    d.wait_req = 1'b1;
                                    d.wait_len = {1'b0, q.a} + 1'b1;
                                    d.st       = ST_WAIT;
                                end
                                default: ;
                            endcase
                            if (ins == X_SHR) begin
                                d.a    = q.a >> 1;
                                d.flag = ~q.a[0];
                            end else begin
                                d.flag = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            ST_LO: begin
                d.st = ST_OP;
                if (q.flag) begin
                    d.pc = {q.hi, ins};
                end else begin
                    d.pc   = q.pc + 1'b1;
                    d.flag = 1'b1;
                end
            end
            ST_WAIT: begin
                if (timer_done) begin
                    d.wait_req = 1'b0;
                    d.st       = ST_OP;
                end
            end
            default: d.st = ST_OP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.flag <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign disp      = q.disp;
    assign disp_load = q.disp_load;
    assign led       = q.led;
    assign tone_req  = q.tone_req;
    assign tone_idx  = q.tone_idx;
    assign wait_req  = q.wait_req;
    assign wait_len  = q.wait_len;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
    import nib_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NIB_W-1:0] disp,
    input logic             disp_load,
    input logic [LED_N-1:0] led,
    input logic             tone_req,
    input logic             wait_req,
    input logic             timer_done
);
    // R12
    tone_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tone_req |=> !tone_req);

    // R13
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_req && !timer_done) |=> wait_req);

    // R13
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wait_req |-> (!tone_req && !disp_load));

    // R3
    disp_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !disp_load |-> (disp == $past(disp)));

    // R11
    led_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(led ^ $past(led)) <= 1);
endmodule

bind nib_core nib_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .disp       (disp),
    .disp_load  (disp_load),
    .led        (led),
    .tone_req   (tone_req),
    .wait_req   (wait_req),
    .timer_done (timer_done)
);

// File: tb/nib_core_tb_top.sv
`timescale 1ns/1ps
module nib_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [7:0] load_addr = '0;
    logic [3:0] load_data = '0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = '0;
    logic       timer_done = 1'b0;
    logic [3:0] disp;
    logic       disp_load;
    logic [6:0] led;
    logic       tone_req;
    logic [3:0] tone_idx;
    logic       wait_req;
    logic [4:0] wait_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] exp_disp[$];
    string      tag_disp[$];
    logic [3:0] exp_tone[$];
    string      tag_tone[$];

    always #2 clk = ~clk;

    nib_core dut_i (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .key_valid(key_valid), .key_code(key_code),
        .timer_done(timer_done), .disp(disp), .disp_load(disp_load), .led(led),
        .tone_req(tone_req), .tone_idx(tone_idx), .wait_req(wait_req),
        .wait_len(wait_len)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_disp(input logic [3:0] v, input string req);
        exp_disp.push_back(v);
        tag_disp.push_back(req);
    endtask

    task automatic push_tone(input logic [3:0] v, input string req);
        exp_tone.push_back(v);
        tag_tone.push_back(req);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && disp_load) begin
            if (exp_disp.size() == 0) begin
                check(1'b0, "R3 unexpected display update", int'(disp), 0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_disp.pop_front();
                t = tag_disp.pop_front();
                check(disp == e, t, int'(disp), int'(e));
            end
        end
        if (!rst && tone_req) begin
            if (exp_tone.size() == 0) begin
                check(1'b0, "R12 unexpected tone", int'(tone_idx), 0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_tone.pop_front();
                t = tag_tone.pop_front();
                check(tone_idx == e, t, int'(tone_idx), int'(e));
            end
        end
    end

    function automatic logic [3:0] hexval(input byte c);
        if (c >= "0" && c <= "9") return 4'(c - "0");
        return 4'(c - "A" + 10);
    endfunction

    task automatic load_prog(input string s);
        rst = 1'b1;
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = 8'(i);
            load_data = hexval(s.getc(i));
        end
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (40) @(negedge clk);
        check(exp_disp.size() == 0, {req, " display items outstanding"}, exp_disp.size(), 0);
        check(exp_tone.size() == 0, {req, " tone items outstanding"}, exp_tone.size(), 0);
        exp_disp.delete(); tag_disp.delete();
        exp_tone.delete(); tag_tone.delete();
    endtask

    initial begin
        // Program 1: arithmetic, memory, swaps, compares, jumps, calls, wait
        load_prog({"85","1","9C","1","A3","4","89","6","1","7","1","80","7","1","5","1",
                   "2","1","2","3","1","C3","E40","C5","E25","1","D1","F4","1","F4","1",
                   "F6","1","F6","F6","E40","1","FB","F5","1","F5","1","A2","F1","FC","1","E47"});
        check(disp == 4'h0 && led == '0, "R1 reset outputs", int'({disp, led}), 0);
        check(!tone_req && !wait_req && !disp_load, "R1 reset strobes",
              int'({tone_req, wait_req, disp_load}), 0);
        push_disp(4'h5, "R5 LIA");
        push_disp(4'h1, "R5 AIA wrap");
        push_disp(4'hA, "R4 ADM sum");
        push_disp(4'h9, "R4 SBM diff");
        push_disp(4'hF, "R4 SBM negative wrap");
        push_disp(4'h1, "R3 STM/LDM at 0x50+Y");
        push_disp(4'h0, "R3 XAB swap");
        push_disp(4'h3, "R3 XAY swap");
        push_disp(4'h3, "R8 skipped call / R6 CIY equal / R7 jump taken");
        push_disp(4'hC, "R9 CMPL");
        push_disp(4'h6, "R9 SHR even");
        push_disp(4'h1, "R9 SHR odd clears flag");
        push_disp(4'h0, "R10 shadow swap in");
        push_disp(4'h1, "R10 shadow swap back");
        push_disp(4'h1, "R13 resume after wait");
        push_tone(4'h1, "R12 tone index from A");
        rst = 1'b0;
        begin
            int n = 0;
            while (!wait_req && n < 500) begin @(negedge clk); n++; end
        end
        check(wait_req == 1'b1, "R13 wait raised", int'(wait_req), 1);
        check(wait_len == 5'd2, "R13 wait length A+1", int'(wait_len), 2);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(wait_req && !disp_load, "R13 stall holds", int'({wait_req, disp_load}), 2);
        end
        check(exp_disp.size() == 1, "R13 no progress while stalled", exp_disp.size(), 1);
        timer_done = 1'b1;
        @(negedge clk);
        timer_done = 1'b0;
        drain("R13");
        check(led == 7'b0000100, "R11 light 2 on", int'(led), 4);

        // Program 2: key present, lights, tone, clear display, unused call
        key_valid = 1'b1;
        key_code  = 4'h7;
        load_prog({"0","E00","1","A7","F1","A0","F1","A6","F1","F2","FB","F0","F9","1","E1A"});
        check(disp == 4'h0 && led == '0, "R1 reset clears state", int'({disp, led}), 0);
        push_disp(4'h7, "R2 key loaded, flag cleared");
        push_disp(4'h0, "R14 clear display");
        push_disp(4'h7, "R8 unused call no effect");
        push_tone(4'h7, "R12 tone index");
        rst = 1'b0;
        drain("R2");
        check(led == 7'b0000001, "R11 lights on/off, index 7 ignored", int'(led), 1);

        // Program 3: no key
        key_valid = 1'b0;
        key_code  = 4'h9;
        load_prog({"84","C4","0","E09","8","1","E0A"});
        push_disp(4'h4, "R2 no key: A kept, flag set / R6 CIA");
        rst = 1'b0;
        drain("R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule